// File: doc/BRIEF.md
# ATM Cell Receive Port (PHY side, 8-bit)

This block is the PHY-side source of an 8-bit UTOPIA-style receive path. Line-side logic writes received ATM cells byte by byte into a FIFO that is organised as a ring of whole cells. The ATM-layer device pulls bytes out with an active-low read enable. Each byte comes with a start-of-cell marker.

One status output tells the ATM layer whether there is data to fetch. It has two meanings, set by a mode input. In single-PHY mode it is an always-driven "bytes present" flag, which is the inverse of an active-low empty flag. In multi-PHY mode it means "a complete cell is available". The flag is then three-state. It is modelled as a value plus an output enable, and the enable is raised only when the sampled 5-bit receive address equals this port's address. A read attempted while the FIFO holds nothing leaves the data unchanged and latches an underflow status bit.

Top module: `utopia_rx_phy`

## Requirements
- R1: A line-side byte is stored on a rising edge when `lw_valid_i` and `lw_ready_o` are both high. `lw_ready_o` is low exactly while the FIFO holds CELL_DEPTH*CELL_BYTES (4*53 = 212) bytes.
- R2: On a rising edge with `rd_en_ni` low and at least one byte held, `rd_data_o` takes the oldest stored byte. Bytes leave in write order. When `rd_en_ni` is high, `rd_data_o` holds its value.
- R3: `rd_soc_o` is loaded together with each read byte. It is 1 when that byte is at offset 0 of its 53-byte cell (cells counted from reset) and 0 otherwise. It holds while `rd_en_ni` is high.
- R4: A read edge with `rd_en_ni` low and no byte held leaves `rd_data_o` unchanged, clears `rd_soc_o` and sets `underflow_o`. `underflow_o` stays set until reset.
- R5: With `multi_phy_i` = 0, `flag_oe_o` is 1. `flag_o` is 1 while any byte is held and 0 when none is held.
- R6: With `multi_phy_i` = 1 and `flag_oe_o` = 1, `flag_o` is 1 while at least one cell has had all 53 bytes written and its last byte not yet read.
- R7: With `multi_phy_i` = 1, `flag_oe_o` is 1 exactly when `rx_addr_i`, sampled on the previous rising edge, equals `port_addr_i`. `flag_o` is 0 whenever `flag_oe_o` is 0.
- R8: During and after reset, the FIFO is empty, `rd_data_o` is 0, `rd_soc_o` is 0, `underflow_o` is 0 and `lw_ready_o` is 1.
- R9: A write and a read on the same edge both take effect. The held byte count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| multi_phy_i | input | 1 | 1 = multi-PHY (cell-available flag), 0 = single-PHY (byte flag) |
| port_addr_i | input | 5 | Address this port answers to |
| rx_addr_i | input | 5 | Receive address from the ATM layer |
| lw_valid_i | input | 1 | Line-side byte valid |
| lw_data_i | input | 8 | Line-side byte |
| lw_ready_o | output | 1 | FIFO can accept a byte |
| rd_en_ni | input | 1 | Read enable, active low |
| rd_data_o | output | 8 | Byte to the ATM layer |
| rd_soc_o | output | 1 | First byte of a cell on `rd_data_o` |
| flag_o | output | 1 | Availability flag value |
| flag_oe_o | output | 1 | Availability flag output enable |
| underflow_o | output | 1 | Sticky read-while-empty status |

## Verification
The bench uses the default parameters: 53-byte cells, 4 cells and a 5-bit address. The whole 212-byte store therefore fills and drains within a few hundred cycles. That covers the full point where ready drops, pointer wrap at the cell and ring boundaries, and several start-of-cell positions. Single-PHY and multi-PHY phases are compared cycle by cycle against a queue model. The multi-PHY phases include a partial cell, address match and mismatch, and draining through the underflow point.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_MULTI  = 1'b1
  } phy_mode_e;
endpackage

// File: rtl/rx_cell_ptr.sv
// Walks byte offset within a cell and cell slot within the ring.
module rx_cell_ptr #(
  parameter int CELL_BYTES = 53,
  parameter int CELL_DEPTH = 4,
  parameter int AW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          first_o,
  output logic          last_o
);
  localparam int OFF_W  = $clog2(CELL_BYTES);
  localparam int CELL_W = (CELL_DEPTH > 1) ? $clog2(CELL_DEPTH) : 1;

  logic [OFF_W-1:0]  off_q;
  logic [CELL_W-1:0] cell_q;

  assign first_o = (off_q == '0);
  assign last_o  = (off_q == OFF_W'(CELL_BYTES - 1));
  assign addr_o  = AW'(cell_q) * AW'(CELL_BYTES) + AW'(off_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      cell_q <= '0;
    end else if (adv_i) begin
      if (last_o) begin
        off_q  <= '0;
        cell_q <= (cell_q == CELL_W'(CELL_DEPTH - 1)) ? '0 : cell_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_byte_mem.sv
module rx_byte_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 212,
  parameter int AW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/rx_avail_flag.sv
// Shared availability pin: byte flag (single) or address-selected cell flag (multi).
module rx_avail_flag
  import utopia_rx_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              multi_phy_i,
  input  logic [ADDR_W-1:0] port_addr_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic              bytes_any_i,
  input  logic              cells_any_i,
  output logic              flag_o,
  output logic              flag_oe_o
);
  logic [ADDR_W-1:0] addr_q;
  phy_mode_e         mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= rx_addr_i;
  end

  assign mode = phy_mode_e'(multi_phy_i);

  always_comb begin
    if (mode == MODE_MULTI) begin
      flag_oe_o = (addr_q == port_addr_i);
      flag_o    = flag_oe_o & cells_any_i;
    end else begin
      flag_oe_o = 1'b1;
      flag_o    = bytes_any_i;
    end
  end

  p_flag_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> flag_oe_o);
  p_single_driven_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !multi_phy_i |-> flag_oe_o);
  p_cell_implies_bytes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cells_any_i |-> bytes_any_i);
endmodule

// File: rtl/utopia_rx_phy.sv
module utopia_rx_phy #(
  parameter int CELL_BYTES = 53,
  parameter int CELL_DEPTH = 4,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              multi_phy_i,
  input  logic [ADDR_W-1:0] port_addr_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic              lw_valid_i,
  input  logic [DATA_W-1:0] lw_data_i,
  output logic              lw_ready_o,
  input  logic              rd_en_ni,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_soc_o,
  output logic              flag_o,
  output logic              flag_oe_o,
  output logic              underflow_o
);
  localparam int TOTAL = CELL_BYTES * CELL_DEPTH;
  localparam int AW    = $clog2(TOTAL);
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam int CC_W  = $clog2(CELL_DEPTH + 1);

  logic [CNT_W-1:0] byte_cnt_q;
  logic [CC_W-1:0]  cell_cnt_q;
  logic [AW-1:0]    waddr, raddr;
  logic             wr_first, wr_last, rd_first, rd_last;
  logic             wr_go, rd_go, rd_try, cell_in, cell_out;

  assign lw_ready_o = (byte_cnt_q != CNT_W'(TOTAL));
  assign wr_go      = lw_valid_i & lw_ready_o;
  assign rd_try     = ~rd_en_ni;
  assign rd_go      = rd_try & (byte_cnt_q != '0);
  assign cell_in    = wr_go & wr_last;
  assign cell_out   = rd_go & rd_last;

  rx_cell_ptr #(.CELL_BYTES(CELL_BYTES), .CELL_DEPTH(CELL_DEPTH), .AW(AW)) u_wr_ptr (
    .clk_i, .rst_ni, .adv_i(wr_go), .addr_o(waddr), .first_o(wr_first), .last_o(wr_last)
  );

  rx_cell_ptr #(.CELL_BYTES(CELL_BYTES), .CELL_DEPTH(CELL_DEPTH), .AW(AW)) u_rd_ptr (
    .clk_i, .rst_ni, .adv_i(rd_go), .addr_o(raddr), .first_o(rd_first), .last_o(rd_last)
  );

  rx_byte_mem #(.DATA_W(DATA_W), .DEPTH(TOTAL), .AW(AW)) u_mem (
    .clk_i, .rst_ni, .we_i(wr_go), .waddr_i(waddr), .wdata_i(lw_data_i),
    .re_i(rd_go), .raddr_i(raddr), .rdata_o(rd_data_o)
  );

  rx_avail_flag #(.ADDR_W(ADDR_W)) u_flag (
    .clk_i, .rst_ni, .multi_phy_i, .port_addr_i, .rx_addr_i,
    .bytes_any_i(byte_cnt_q != '0), .cells_any_i(cell_cnt_q != '0),
    .flag_o, .flag_oe_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_cnt_q  <= '0;
      cell_cnt_q  <= '0;
      rd_soc_o    <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      case ({wr_go, rd_go})
        2'b10:   byte_cnt_q <= byte_cnt_q + 1'b1;
        2'b01:   byte_cnt_q <= byte_cnt_q - 1'b1;
        default: byte_cnt_q <= byte_cnt_q;
      endcase
      case ({cell_in, cell_out})
        2'b10:   cell_cnt_q <= cell_cnt_q + 1'b1;
        2'b01:   cell_cnt_q <= cell_cnt_q - 1'b1;
        default: cell_cnt_q <= cell_cnt_q;
      endcase
      if (rd_go)       rd_soc_o <= rd_first;
      else if (rd_try) rd_soc_o <= 1'b0;
      if (rd_try && !rd_go) underflow_o <= 1'b1;
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cnt_q <= CNT_W'(TOTAL));
  p_underflow_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
  p_empty_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_try && byte_cnt_q == '0) |=> (!rd_soc_o && $stable(rd_data_o) && underflow_o));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_ni |=> ($stable(rd_data_o) && $stable(rd_soc_o)));
  p_both_sides_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && rd_go) |=> $stable(byte_cnt_q));
  p_write_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && wr_first) |-> !wr_last);
endmodule

// File: tb/tb_utopia_rx_phy.sv
module tb_utopia_rx_phy;
  localparam int CB    = 53;
  localparam int CD    = 4;
  localparam int TOTAL = CB * CD;
  localparam logic [4:0] PORT = 5'd9;

  logic       clk_i = 0, rst_ni = 0;
  logic       multi_phy_i = 0;
  logic [4:0] rx_addr_i = '0;
  logic       lw_valid_i = 0;
  logic [7:0] lw_data_i = '0;
  logic       rd_en_ni = 1;
  logic       lw_ready_o, rd_soc_o, flag_o, flag_oe_o, underflow_o;
  logic [7:0] rd_data_o;

  int n_tests = 0, n_fail = 0;
  logic [7:0] seed = 8'h10;

  always #10 clk_i = ~clk_i;

  utopia_rx_phy dut (
    .clk_i, .rst_ni, .multi_phy_i, .port_addr_i(PORT), .rx_addr_i,
    .lw_valid_i, .lw_data_i, .lw_ready_o, .rd_en_ni, .rd_data_o,
    .rd_soc_o, .flag_o, .flag_oe_o, .underflow_o
  );

  // behavioural reference
  logic [7:0] q[$];
  int   wr_off, rd_off, full_cells;
  logic [7:0] m_data;
  logic m_soc, m_uf;
  logic [4:0] m_addr;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete(); wr_off = 0; rd_off = 0; full_cells = 0;
      m_data = 0; m_soc = 0; m_uf = 0; m_addr = 0;
    end else begin
      automatic int  sz = q.size();
      automatic bit  rd = !rd_en_ni && sz > 0;
      automatic bit  wr = lw_valid_i && sz < TOTAL;
      if (rd) begin
        m_data = q.pop_front();
        m_soc  = (rd_off == 0);
        if (rd_off == CB - 1) begin rd_off = 0; full_cells--; end
        else rd_off++;
      end else if (!rd_en_ni) begin
        m_soc = 0; m_uf = 1;
      end
      if (wr) begin
        q.push_back(lw_data_i);
        if (wr_off == CB - 1) begin wr_off = 0; full_cells++; end
        else wr_off++;
      end
      m_addr = rx_addr_i;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    automatic bit e_oe, e_flag;
    if (!rst_ni) begin
      chk("R8", "ready", lw_ready_o, 1);
      chk("R8", "data", rd_data_o, 0);
      chk("R8", "soc", rd_soc_o, 0);
      chk("R8", "underflow", underflow_o, 0);
    end else begin
      if (multi_phy_i) begin
        e_oe = (m_addr == PORT);
        e_flag = e_oe && full_cells > 0;
      end else begin
        e_oe = 1; e_flag = q.size() > 0;
      end
      chk("R1", "ready", lw_ready_o, q.size() < TOTAL);
      chk("R2", "data", rd_data_o, m_data);
      chk("R3", "soc", rd_soc_o, m_soc);
      chk("R4", "underflow", underflow_o, m_uf);
      chk(multi_phy_i ? "R7" : "R5", "oe", flag_oe_o, e_oe);
      chk(multi_phy_i ? "R6" : "R5", "flag", flag_o, e_flag);
    end
  end

  task automatic cyc(bit v, bit rn);
    @(posedge clk_i); #2;
    lw_valid_i = v; rd_en_ni = rn;
    if (v) begin lw_data_i = seed; seed = seed + 8'd7; end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    // R5: single-PHY, partial cell written then partly read
    repeat (10) cyc(1, 1);
    repeat (3) cyc(0, 0);
    cyc(0, 1);
    // R1/R3: complete two cells, then fill until ready drops
    repeat (100) cyc(1, 1);
    repeat (120) cyc(1, 1);
    // R9: concurrent write and read at the full point and below
    repeat (30) cyc(1, 0);
    repeat (20) cyc(0, 0);
    repeat (20) cyc(1, 0);
    // R6/R7: multi-PHY, address mismatch then match
    multi_phy_i = 1;
    rx_addr_i = 5'd3;
    repeat (5) cyc(0, 1);
    rx_addr_i = PORT;
    repeat (5) cyc(0, 1);
    // drain through underflow (R4), flag must fall after the last full cell
    repeat (TOTAL + 10) cyc(0, 0);
    // R6: partial cell does not raise the cell flag; completing it does
    repeat (20) cyc(1, 1);
    repeat (CB - 20) cyc(1, 1);
    rx_addr_i = 5'd0;
    repeat (4) cyc(0, 0);
    rx_addr_i = PORT;
    repeat (CB + 5) cyc(0, 0);
    // back to single mode
    multi_phy_i = 0;
    repeat (5) cyc(1, 1);
    repeat (8) cyc(0, 0);
    cyc(0, 1);
    repeat (2) @(posedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule